// File: doc/BRIEF.md
# Serial Port Data Buffer Interface

This block is the processor-side data register of an asynchronous serial port. A single bus address reaches two separate stores. A bus write goes to a one-entry transmit holding buffer. A bus read returns the oldest character in a two-entry receive queue. The transmit side keeps a buffer-empty flag. A write is taken only while that flag is high, and a write made while it is low is lost without any notice.

When the transmitter is enabled and the external shift register reports that it is idle, the held byte is passed to that register and the holding buffer is freed. Completed characters from an external receive shifter are pushed into the queue. If a character arrives while the queue is full, it is discarded and a sticky overrun flag is raised. Every bus read pops the queue, so reads have a side effect.

A 2-bit character-size input selects a character length of 5 to 8 bits. It masks the unused high bits of the byte sent to the shift register and of the byte read back from the queue.

Top module: `sio_data_port`

## Requirements
- R1: After reset, `dre_flag` is 1, `rxc_flag` is 0, `ovr_flag` is 0, `shift_load` is 0 and `bus_rdata` reads 0x00.
- R2: A write (`bus_wr`=1) while `dre_flag`=1 is accepted into the holding buffer, and `dre_flag` reads 0 after that clock edge.
- R3: A write while `dre_flag`=0 is discarded. The byte already held is the one later handed to the shift register.
- R4: `shift_load` is high in exactly those cycles in which a byte is held, `tx_enable`=1 and `shift_empty`=1. In such a cycle `shift_data` carries the held byte, and `dre_flag` reads 1 after the edge. While `tx_enable`=0 or `shift_empty`=0, the byte stays held.
- R5: `char_size` encodes 00=5, 01=6, 10=7 and 11=8 data bits. Bits of `shift_data` at positions equal to or above the character length read 0.
- R6: The receive queue holds two characters in arrival order. `rxc_flag` is 1 while at least one is held, and `bus_rdata` shows the oldest one in the same cycle.
- R7: Every cycle with `bus_rd`=1 pops one entry if any is held. A read of an empty queue returns 0x00 and leaves the queue empty.
- R8: Bits of `bus_rdata` at positions equal to or above the character length read 0, using the same encoding as R5.
- R9: A character pushed (`rx_valid`=1) while both entries are full and no read occurs is dropped, the stored entries are kept, and `ovr_flag` sets. `ovr_flag` clears after the next read that pops an entry.
- R10: A push and a popping read in the same cycle both take effect, and the occupancy stays the same. This also holds when the queue is full, in which case no overrun occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe to the data address |
| bus_rd | input | 1 | Bus read strobe from the data address (pops the queue) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: masked head of the receive queue |
| char_size | input | 2 | Character length select |
| tx_enable | input | 1 | Transmitter enable |
| shift_empty | input | 1 | External transmit shift register is idle |
| shift_load | output | 1 | Transfer strobe to the transmit shift register |
| shift_data | output | 8 | Masked byte for the transmit shift register |
| rx_valid | input | 1 | Receive shifter has a completed character |
| rx_data | input | 8 | Completed received character |
| dre_flag | output | 1 | Transmit holding buffer empty |
| rxc_flag | output | 1 | Receive queue holds at least one character |
| ovr_flag | output | 1 | Sticky receive overrun |

## Verification
A bus read that pops the receive queue and a character arriving from the receive shifter can land on the same clock edge. The bench provokes this with the queue holding one entry and again with it full, raising `bus_rd` and `rx_valid` together in one vector. Each case is judged by the read data in that cycle, by the next read returning the entry that was second and then the new character in order, by `rxc_flag` staying high, and by `ovr_flag` staying low.

// File: rtl/sio_dp_pkg.sv
package sio_dp_pkg;

    // Character length select; value is length minus the shortest length
    typedef enum logic [1:0] {
        CLEN_5 = 2'b00,
        CLEN_6 = 2'b01,
        CLEN_7 = 2'b10,
        CLEN_8 = 2'b11
    } clen_e;

    localparam int unsigned SHORTEST_CHAR = 5;

endpackage

// File: rtl/sio_char_mask.sv
module sio_char_mask #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned MIN_BITS = sio_dp_pkg::SHORTEST_CHAR,
    parameter int unsigned SEL_W    = 2
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] mask
);
    // One bit per data position: kept when below the selected length
    for (genvar g = 0; g < int'(DATA_W); g++) begin : g_bit
        assign mask[g] = (32'(g) < (MIN_BITS + 32'(sel)));
    end
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              shift_empty,
    input  logic [DATA_W-1:0] mask,
    output logic              empty_flag,
    output logic              load,
    output logic [DATA_W-1:0] load_data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = st_q.full && tx_enable && shift_empty;
        if (load) begin
            st_d.full = 1'b0;
        end
        // Writes only land while the buffer is free
        if (wr_en && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_flag = !st_q.full;
    assign load_data  = st_q.data & mask;
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              not_empty,
    output logic              overrun
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rd_ptr;
        logic [PTR_W-1:0]             wr_ptr;
        logic [CNT_W-1:0]             count;
        logic                         ovr;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_pop, do_push, drop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.count != '0);
        do_push = push && ((st_q.count < FULL) || do_pop);
        drop    = push && !do_push;

        if (do_push) begin
            st_d.mem[st_q.wr_ptr] = push_data;
            st_d.wr_ptr = (st_q.wr_ptr == LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase

        if (drop) begin
            st_d.ovr = 1'b1;
        end else if (do_pop) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign not_empty = (st_q.count != '0);
    assign head      = not_empty ? st_q.mem[st_q.rd_ptr] : '0;
    assign overrun   = st_q.ovr;
endmodule

// File: rtl/sio_data_port.sv
module sio_data_port #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        char_size,
    input  logic              tx_enable,
    input  logic              shift_empty,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              dre_flag,
    output logic              rxc_flag,
    output logic              ovr_flag
);
    logic [DATA_W-1:0] len_mask;
    logic [DATA_W-1:0] rx_head;

    sio_char_mask #(
        .DATA_W (DATA_W),
        .SEL_W  (2)
    ) u_mask (
        .sel  (char_size),
        .mask (len_mask)
    );

    sio_tx_hold #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr),
        .wr_data     (bus_wdata),
        .tx_enable   (tx_enable),
        .shift_empty (shift_empty),
        .mask        (len_mask),
        .empty_flag  (dre_flag),
        .load        (shift_load),
        .load_data   (shift_data)
    );

    sio_rx_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (RX_DEPTH)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (bus_rd),
        .head      (rx_head),
        .not_empty (rxc_flag),
        .overrun   (ovr_flag)
    );

    assign bus_rdata = rx_head & len_mask;
endmodule

// File: rtl/sio_data_port_sva.sv
module sio_data_port_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic [1:0] char_size,
    input logic       tx_enable,
    input logic       shift_empty,
    input logic       shift_load,
    input logic [7:0] shift_data,
    input logic       rx_valid,
    input logic       dre_flag,
    input logic       rxc_flag,
    input logic       ovr_flag
);
    p_accept_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && dre_flag |=> !dre_flag);

    p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !dre_flag && !shift_load |=>
            !dre_flag && (shift_data == $past(shift_data) || char_size != $past(char_size)));

    p_load_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |-> tx_enable && shift_empty && !dre_flag);

    p_load_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |=> dre_flag);

    p_tx_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load && char_size == 2'b00 |-> shift_data[7:5] == 3'b000);

    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rxc_flag |-> bus_rdata == 8'h00);

    p_rx_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        char_size == 2'b01 |-> bus_rdata[7:6] == 2'b00);

    p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && rxc_flag |=> !ovr_flag);

    p_swap_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && rx_valid && rxc_flag |=> rxc_flag);
endmodule

bind sio_data_port sio_data_port_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .char_size   (char_size),
    .tx_enable   (tx_enable),
    .shift_empty (shift_empty),
    .shift_load  (shift_load),
    .shift_data  (shift_data),
    .rx_valid    (rx_valid),
    .dre_flag    (dre_flag),
    .rxc_flag    (rxc_flag),
    .ovr_flag    (ovr_flag)
);

// File: tb/sio_data_port_test.sv
module sio_data_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] char_size = 2'b11;
    logic       tx_enable = 1'b0;
    logic       shift_empty = 1'b1;
    logic       shift_load;
    logic [7:0] shift_data;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       dre_flag, rxc_flag, ovr_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sio_data_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .char_size(char_size),
        .tx_enable(tx_enable), .shift_empty(shift_empty), .shift_load(shift_load),
        .shift_data(shift_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .dre_flag(dre_flag), .rxc_flag(rxc_flag), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Receive-side vectors: inputs for one cycle and the outputs seen before its edge
    typedef struct packed {
        logic       rd;
        logic       push;
        logic [7:0] din;
        logic [1:0] sz;
        logic [7:0] e_rdata;
        logic       e_rxc;
        logic       e_ovr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'h00, 2'b11, 8'h00, 1'b0, 1'b0}, // R7 read of empty queue
        '{1'b0, 1'b1, 8'hA5, 2'b11, 8'h00, 1'b0, 1'b0}, // R6 first push
        '{1'b0, 1'b1, 8'h3C, 2'b11, 8'hA5, 1'b1, 1'b0}, // R6 second push
        '{1'b0, 1'b1, 8'hFF, 2'b11, 8'hA5, 1'b1, 1'b0}, // R9 push to full queue dropped
        '{1'b1, 1'b0, 8'h00, 2'b11, 8'hA5, 1'b1, 1'b1}, // R9 overrun seen, read pops
        '{1'b1, 1'b1, 8'h81, 2'b11, 8'h3C, 1'b1, 1'b0}, // R10 pop and push at one entry
        '{1'b0, 1'b1, 8'h42, 2'b11, 8'h81, 1'b1, 1'b0}, // R6 fill again
        '{1'b1, 1'b1, 8'h99, 2'b11, 8'h81, 1'b1, 1'b0}, // R10 pop and push while full
        '{1'b0, 1'b0, 8'h00, 2'b00, 8'h02, 1'b1, 1'b0}, // R8 5-bit view of 0x42, no overrun
        '{1'b1, 1'b0, 8'h00, 2'b11, 8'h42, 1'b1, 1'b0}, // R10 order kept
        '{1'b1, 1'b0, 8'h00, 2'b01, 8'h19, 1'b1, 1'b0}, // R8 6-bit view of 0x99
        '{1'b1, 1'b0, 8'h00, 2'b11, 8'h00, 1'b0, 1'b0}, // R7 empty again, no underflow
        '{1'b0, 1'b0, 8'h00, 2'b11, 8'h00, 1'b0, 1'b0}  // R7 still empty
    };

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 dre_flag", 8'(dre_flag), 8'h01);
        chk("R1 rxc_flag", 8'(rxc_flag), 8'h00);
        chk("R1 ovr_flag", 8'(ovr_flag), 8'h00);
        chk("R1 shift_load", 8'(shift_load), 8'h00);
        chk("R1 bus_rdata", bus_rdata, 8'h00);

        // R2 accepted write, transmitter disabled
        bus_write(8'hA7);
        chk("R2 dre_flag after write", 8'(dre_flag), 8'h00);
        chk("R4 no load while disabled", 8'(shift_load), 8'h00);

        // R3 write while buffer busy is lost
        bus_write(8'h11);
        chk("R3 dre_flag after dropped write", 8'(dre_flag), 8'h00);

        // R4 transfer gating
        @(negedge clk);
        tx_enable = 1'b1;
        shift_empty = 1'b0;
        #1 chk("R4 no load while shifter busy", 8'(shift_load), 8'h00);
        @(posedge clk);
        #1 chk("R4 byte still held", 8'(dre_flag), 8'h00);
        @(negedge clk);
        shift_empty = 1'b1;
        #1 chk("R4 load strobe", 8'(shift_load), 8'h01);
        chk("R3 held byte survives dropped write", shift_data, 8'hA7);
        @(posedge clk);
        #1 tx_enable = 1'b0;
        chk("R4 dre_flag after transfer", 8'(dre_flag), 8'h01);
        chk("R4 strobe ends", 8'(shift_load), 8'h00);

        // R5 transmit masking per length
        for (int s = 0; s < 3; s++) begin
            logic [7:0] exp_m;
            exp_m = 8'((9'h1 << (5 + s)) - 9'h1);
            bus_write(8'hFF);
            @(negedge clk);
            char_size = 2'(s);
            tx_enable = 1'b1;
            #1 chk("R5 shift_data masked", shift_data, exp_m);
            chk("R5 load strobe", 8'(shift_load), 8'h01);
            @(posedge clk);
            #1 tx_enable = 1'b0;
            char_size = 2'b11;
        end

        // Receive queue vectors: R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_rd = VECS[i].rd;
            rx_valid = VECS[i].push;
            rx_data = VECS[i].din;
            char_size = VECS[i].sz;
            #1;
            chk($sformatf("R6-R10 vec %0d rdata", i), bus_rdata, VECS[i].e_rdata);
            chk($sformatf("R6 vec %0d rxc_flag", i), 8'(rxc_flag), 8'(VECS[i].e_rxc));
            chk($sformatf("R9 vec %0d ovr_flag", i), 8'(ovr_flag), 8'(VECS[i].e_ovr));
            @(posedge clk);
        end
        #1;
        bus_rd = 1'b0;
        rx_valid = 1'b0;
        char_size = 2'b11;

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule